// File: doc/BRIEF.md
# PLL Loop Power-State Sequencer

This block decides, every clock, whether one synthesizer loop is running, running with its charge pump in high impedance, or powered down. It combines an asynchronous enable pin, a register power-down bit, a register charge-pump high-impedance bit, a two-bit auto-power-up field and a strobe that marks a write to the feedback divider. From these it drives a loop power-down signal, a charge-pump enable and a charge-pump high-impedance control.

Power-down comes in two forms. The graceful form stops new charge-pump pulses and then waits for the pulse in progress to end, as shown by a busy line, before it asserts power-down. A programmable timeout forces power-down if the busy line never clears, for example when no oscillator signal reaches the divider. The abrupt form asserts power-down at once. Power-up always deasserts loop power-down one clock before it enables the charge pump.

Top module: `pll_pdn_seq`

## Requirements
- R1: A low enable pin overrides every other input. `loop_pd` is high three clocks after the pin falls (two synchronizer stages and one state register), whatever `cp_busy` shows. A low pin also clears any auto-power-up override.
- R2: With the enable pin high, `pd_bit`=0 and `hiz_bit`=0, the outputs settle to `loop_pd`=0, `cp_en`=1 and `cp_hiz`=0.
- R3: With the enable pin high, `pd_bit`=0 and `hiz_bit`=1, the outputs settle to `loop_pd`=0, `cp_en`=0 and `cp_hiz`=1.
- R4: With `pd_bit`=1 and `hiz_bit`=0, a running loop enters a wait state one clock later, with `loop_pd`=0, `cp_en`=0 and `cp_hiz`=0. `loop_pd` then rises on the first clock edge at which `cp_busy` is low. While the loop is down, `cp_en`=0 and `cp_hiz`=1.
- R5: If `cp_busy` stays high in the wait state, `loop_pd` rises `tmo_lim`+1 clocks after the wait state is entered. With `tmo_lim`=0 this takes one clock.
- R6: With `pd_bit`=1 and `hiz_bit`=1, `loop_pd` is high one clock later from any state, whatever `cp_busy` shows.
- R7: With the enable pin high, a nonzero `apu_mode` and an `fb_wr` pulse, the loop is forced to run normally whatever `pd_bit` and `hiz_bit` hold. From the wait state it returns to running one clock later. The override holds until a `cfg_wr` pulse arrives while `pd_bit`=1. An `fb_wr` pulse with `apu_mode`=0 has no effect.
- R8: Leaving power-down, `loop_pd` falls first with `cp_en`=0 and `cp_hiz`=1. `cp_en` rises one clock later. The charge pump is never enabled while `loop_pd` is high.
- R9: While `rst` is high, `loop_pd`=1, `cp_en`=0 and `cp_hiz`=1.
- R10: Each of the `apu_mode` values 1, 2 and 3 enables the auto-power-up override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_pin | input | 1 | Chip enable pin, asynchronous; low forces abrupt power-down |
| pd_bit | input | 1 | Register power-down bit |
| hiz_bit | input | 1 | Register charge-pump high-impedance bit |
| apu_mode | input | 2 | Auto-power-up field; any nonzero value enables the override |
| cfg_wr | input | 1 | One-clock strobe: the register holding `pd_bit` was written |
| fb_wr | input | 1 | One-clock strobe: the feedback divider was written |
| cp_busy | input | 1 | Charge-pump pulse in progress |
| tmo_lim | input | 16 | Clocks to wait for `cp_busy`, minus one, before forcing power-down |
| loop_pd | output | 1 | Loop power-down |
| cp_en | output | 1 | Charge pump allowed to drive pulses |
| cp_hiz | output | 1 | Charge-pump output in high impedance |

## Verification
Every result depends on clock edges: the register-driven transitions are due one clock after the stimulus, a change on the enable pin takes three, and power-up shows its two steps on two consecutive clocks. The graceful path is due on the first edge at which busy is low, or `tmo_lim`+1 clocks after the wait state is entered. The bench changes inputs on falling edges and counts rising edges before it samples. Each directed check reads the outputs on the exact clock where a value first becomes due, and also one clock earlier where the requirement says the value must not yet have changed.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_HIZ  = 3'd1,
        ST_WAIT = 3'd2,
        ST_DOWN = 3'd3,
        ST_WAKE = 3'd4
    } pd_state_e;

    typedef enum logic [1:0] {
        RQ_RUN   = 2'd0,
        RQ_HIZ   = 2'd1,
        RQ_SYNC  = 2'd2,
        RQ_ASYNC = 2'd3
    } pd_req_e;

    typedef struct packed {
        logic loop_pd;
        logic cp_en;
        logic cp_hiz;
    } pd_out_t;

    // Priority: pin, then auto-power-up override, then register bits.
    function automatic pd_req_e decode_req(input logic en, input logic ovr,
                                           input logic pd, input logic hiz);
        pd_req_e r;
        if (!en)          r = RQ_ASYNC;
        else if (ovr)     r = RQ_RUN;
        else if (!pd)     r = hiz ? RQ_HIZ : RQ_RUN;
        else              r = hiz ? RQ_ASYNC : RQ_SYNC;
        return r;
    endfunction

    function automatic pd_out_t state_outputs(input pd_state_e s);
        pd_out_t o;
        case (s)
            ST_RUN:  o = '{loop_pd: 1'b0, cp_en: 1'b1, cp_hiz: 1'b0};
            ST_HIZ:  o = '{loop_pd: 1'b0, cp_en: 1'b0, cp_hiz: 1'b1};
            ST_WAIT: o = '{loop_pd: 1'b0, cp_en: 1'b0, cp_hiz: 1'b0};
            ST_WAKE: o = '{loop_pd: 1'b0, cp_en: 1'b0, cp_hiz: 1'b1};
            default: o = '{loop_pd: 1'b1, cp_en: 1'b0, cp_hiz: 1'b1};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/pdseq_apu.sv
module pdseq_apu #(
    parameter int APU_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_sync,
    input  logic [APU_W-1:0] apu_mode,
    input  logic             fb_wr,
    input  logic             cfg_wr,
    input  logic             pd_bit,
    output logic             ovr_eff
);
    logic ovr_q;
    logic set_ev;
    logic clr_ev;

    assign set_ev  = en_sync && (|apu_mode) && fb_wr;
    assign clr_ev  = cfg_wr && pd_bit;
    // A divider write wins over a same-cycle clear.
    assign ovr_eff = set_ev || (ovr_q && !clr_ev);

    always_ff @(posedge clk) begin
        if (rst) ovr_q <= 1'b0;
        else     ovr_q <= en_sync && ovr_eff;
    end
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
    import pdseq_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  pd_req_e          req,
    input  logic             cp_busy,
    input  logic [TMO_W-1:0] tmo_lim,
    output pd_state_e        st,
    output logic [TMO_W-1:0] wcnt
);
    pd_state_e        nxt;
    logic [TMO_W-1:0] cnt_d;

    always_comb begin
        nxt   = st;
        cnt_d = wcnt;
        case (req)
            RQ_ASYNC: nxt = ST_DOWN;
            RQ_SYNC: begin
                case (st)
                    ST_RUN, ST_HIZ: begin
                        nxt   = ST_WAIT;
                        cnt_d = '0;
                    end
                    ST_WAIT: begin
                        if (!cp_busy || wcnt == tmo_lim) nxt = ST_DOWN;
                        else                             cnt_d = wcnt + 1'b1;
                    end
                    default: nxt = ST_DOWN;
                endcase
            end
            default: begin
                if (st == ST_DOWN)     nxt = ST_WAKE;
                else if (req == RQ_HIZ) nxt = ST_HIZ;
                else                   nxt = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_DOWN;
            wcnt <= '0;
        end else begin
            st   <= nxt;
            wcnt <= cnt_d;
        end
    end
endmodule

// File: rtl/pll_pdn_seq.sv
module pll_pdn_seq
    import pdseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int APU_W       = 2,
    parameter int TMO_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_pin,
    input  logic             pd_bit,
    input  logic             hiz_bit,
    input  logic [APU_W-1:0] apu_mode,
    input  logic             cfg_wr,
    input  logic             fb_wr,
    input  logic             cp_busy,
    input  logic [TMO_W-1:0] tmo_lim,
    output logic             loop_pd,
    output logic             cp_en,
    output logic             cp_hiz
);
    logic             en_sync;
    logic             ovr_eff;
    pd_req_e          req;
    pd_state_e        st;
    logic [TMO_W-1:0] wcnt;
    pd_out_t          outs;

    pdseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (en_pin),
        .q   (en_sync)
    );

    pdseq_apu #(.APU_W(APU_W)) u_apu (
        .clk      (clk),
        .rst      (rst),
        .en_sync  (en_sync),
        .apu_mode (apu_mode),
        .fb_wr    (fb_wr),
        .cfg_wr   (cfg_wr),
        .pd_bit   (pd_bit),
        .ovr_eff  (ovr_eff)
    );

    assign req = decode_req(en_sync, ovr_eff, pd_bit, hiz_bit);

    pdseq_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .cp_busy (cp_busy),
        .tmo_lim (tmo_lim),
        .st      (st),
        .wcnt    (wcnt)
    );

    assign outs    = state_outputs(st);
    assign loop_pd = outs.loop_pd;
    assign cp_en   = outs.cp_en;
    assign cp_hiz  = outs.cp_hiz;
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk
    import pdseq_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en_sync,
    input logic             cp_busy,
    input logic [TMO_W-1:0] tmo_lim,
    input logic [TMO_W-1:0] wcnt,
    input pd_req_e          req,
    input pd_state_e        st,
    input logic             loop_pd,
    input logic             cp_en,
    input logic             cp_hiz
);
    p_pin_low_down_r1: assert property (@(posedge clk) disable iff (rst)
        !en_sync |=> loop_pd);

    p_drive_not_hiz_r2: assert property (@(posedge clk) disable iff (rst)
        cp_en |-> !cp_hiz);

    p_wait_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && req == RQ_SYNC && cp_busy && wcnt != tmo_lim) |=> !loop_pd);

    p_wait_exits_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && req == RQ_SYNC && (!cp_busy || wcnt == tmo_lim)) |=> loop_pd);

    p_async_down_r6: assert property (@(posedge clk) disable iff (rst)
        (req == RQ_ASYNC) |=> loop_pd);

    p_no_pump_when_down_r8: assert property (@(posedge clk) disable iff (rst)
        loop_pd |-> !cp_en);

    p_wake_order_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(loop_pd) |-> !cp_en);

    p_pump_after_up_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(cp_en) |-> !$past(loop_pd));
endmodule

bind pll_pdn_seq pdseq_chk #(.TMO_W(TMO_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_sync (en_sync),
    .cp_busy (cp_busy),
    .tmo_lim (tmo_lim),
    .wcnt    (wcnt),
    .req     (req),
    .st      (st),
    .loop_pd (loop_pd),
    .cp_en   (cp_en),
    .cp_hiz  (cp_hiz)
);

// File: tb/tb_pll_pdn_seq.sv
module tb_pll_pdn_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        en_pin, pd_bit, hiz_bit, cfg_wr, fb_wr, cp_busy;
    logic [1:0]  apu_mode;
    logic [15:0] tmo_lim;
    logic        loop_pd, cp_en, cp_hiz;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pll_pdn_seq dut (
        .clk(clk), .rst(rst), .en_pin(en_pin), .pd_bit(pd_bit), .hiz_bit(hiz_bit),
        .apu_mode(apu_mode), .cfg_wr(cfg_wr), .fb_wr(fb_wr), .cp_busy(cp_busy),
        .tmo_lim(tmo_lim), .loop_pd(loop_pd), .cp_en(cp_en), .cp_hiz(cp_hiz)
    );

    // {pd_bit, hiz_bit, cp_busy, exp loop_pd, exp cp_en, exp cp_hiz}
    localparam logic [5:0] VEC [6] = '{
        6'b000_010,   // R2
        6'b010_001,   // R3
        6'b100_101,   // R4
        6'b001_010,   // R2 busy ignored
        6'b111_101,   // R6
        6'b011_001    // R3
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic chk3(input string tag, input logic p, input logic e, input logic h);
        chk({tag, " loop_pd"}, loop_pd, p);
        chk({tag, " cp_en"},   cp_en,   e);
        chk({tag, " cp_hiz"},  cp_hiz,  h);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en_pin = 1'b1; pd_bit = 1'b0; hiz_bit = 1'b0;
        apu_mode = 2'd0; cfg_wr = 1'b0; fb_wr = 1'b0; cp_busy = 1'b0;
        tmo_lim = 16'd1000;
        tick(3);
        chk3("R9 reset", 1'b1, 1'b0, 1'b1);
        rst = 1'b0;
        tick(6);

        // Static settings: R2, R3, R4, R6
        for (int i = 0; i < 6; i++) begin
            pd_bit = VEC[i][5]; hiz_bit = VEC[i][4]; cp_busy = VEC[i][3];
            tick(5);
            chk3($sformatf("R2/R3/R4/R6 vec%0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R1 and R8: pin timing and power-up order
        pd_bit = 1'b0; hiz_bit = 1'b0; tick(4);
        cp_busy = 1'b1; en_pin = 1'b0;
        tick(2); chk("R1 not yet down", loop_pd, 1'b0);
        tick(1); chk3("R1 pin down", 1'b1, 1'b0, 1'b1);
        en_pin = 1'b1;
        tick(2); chk("R8 still down", loop_pd, 1'b1);
        tick(1); chk3("R8 wake step", 1'b0, 1'b0, 1'b1);
        tick(1); chk3("R8 pump released", 1'b0, 1'b1, 1'b0);

        // R4: graceful power-down waits for busy low
        tmo_lim = 16'd100; pd_bit = 1'b1;
        tick(1); chk3("R4 wait entry", 1'b0, 1'b0, 1'b0);
        tick(3); chk("R4 still waiting", loop_pd, 1'b0);
        cp_busy = 1'b0;
        tick(1); chk3("R4 down on idle", 1'b1, 1'b0, 1'b1);

        // R7: apu_mode 0 ignored
        fb_wr = 1'b1; tick(1); fb_wr = 1'b0;
        chk("R7 apu zero ignored", loop_pd, 1'b1);
        // R10: apu_mode 1 from down
        apu_mode = 2'd1; fb_wr = 1'b1; tick(1); fb_wr = 1'b0;
        chk3("R10 apu1 wake", 1'b0, 1'b0, 1'b1);
        tick(1); chk3("R10 apu1 run", 1'b0, 1'b1, 1'b0);
        tick(5); chk("R7 override persists", cp_en, 1'b1);
        // R7: clear by cfg_wr with pd_bit set
        cp_busy = 1'b1; cfg_wr = 1'b1; tick(1); cfg_wr = 1'b0;
        chk3("R7 cleared to wait", 1'b0, 1'b0, 1'b0);
        // R7/R10: apu_mode 3 from wait, one clock
        apu_mode = 2'd3; fb_wr = 1'b1; tick(1); fb_wr = 1'b0;
        chk3("R7 wait to run apu3", 1'b0, 1'b1, 1'b0);
        // R6: clear with hiz set -> abrupt down
        apu_mode = 2'd2; hiz_bit = 1'b1; cfg_wr = 1'b1; tick(1); cfg_wr = 1'b0;
        chk("R6 abrupt down busy", loop_pd, 1'b1);
        // R10: apu_mode 2
        fb_wr = 1'b1; tick(1); fb_wr = 1'b0; tick(1);
        chk("R10 apu2 run", cp_en, 1'b1);
        cfg_wr = 1'b1; tick(1); cfg_wr = 1'b0;

        // R5: timeout with busy stuck
        pd_bit = 1'b0; hiz_bit = 1'b0; tick(2);
        chk("R5 start running", cp_en, 1'b1);
        tmo_lim = 16'd5; cp_busy = 1'b1; pd_bit = 1'b1;
        tick(6); chk("R5 before timeout", loop_pd, 1'b0);
        tick(1); chk("R5 timeout down", loop_pd, 1'b1);
        // R5: zero limit
        pd_bit = 1'b0; tick(2);
        tmo_lim = 16'd0; pd_bit = 1'b1;
        tick(1); chk("R5 zero lim wait", loop_pd, 1'b0);
        tick(1); chk("R5 zero lim down", loop_pd, 1'b1);

        // R1: pin low clears override
        cp_busy = 1'b0; apu_mode = 2'd1; fb_wr = 1'b1; tick(1); fb_wr = 1'b0;
        tick(1); chk("R1 override running", cp_en, 1'b1);
        en_pin = 1'b0; tick(3); chk("R1 pin beats override", loop_pd, 1'b1);
        en_pin = 1'b1; tick(4); chk("R1 override cleared", loop_pd, 1'b1);

        // R9: reset mid-run
        pd_bit = 1'b0; tick(3);
        rst = 1'b1; tick(1);
        chk3("R9 reset mid-run", 1'b1, 1'b0, 1'b1);
        rst = 1'b0; tick(2);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule